// File: doc/BRIEF.md
# Board Error Status and Signalling Controller

This block gathers the error conditions seen on one board and turns them into the board's error outputs. It drives a crate-wide SVT error line and a global CDF error line. It also drives an open-collector lost-lock backplane line, a daisy-chained lost-lock OR toward the crate controller, and three front-panel LEDs for run, CDF error and SVT error.

Errors come in two classes. Severe errors need a system re-sync to recover: link lost-lock, lost-sync and FIFO overflow. Non-severe errors may clear by themselves when the next event ends.

Lost-sync is found by comparing each received event tag with a locally kept expected tag. All conditions are held in a sticky error register. Software clears it over a simple register strobe bus, and INIT clears it too. An optional shadow register keeps the first cause of an SVT error and is not touched by INIT.

Asynchronous inputs (link lock status, backplane line, chain input) pass through two-flop synchronizers. `rst_n` is asserted asynchronously. It must be released synchronously to `clk` by the system.

Top module: `board_err_ctrl`

## Requirements
- R1: On each end-of-event strobe, error bit 1 (lost-sync) is set if and only if `evt_tag_i` differs from the expected tag. The expected tag is 0 after reset or INIT and increases by one (modulo 256) with every end-of-event strobe.
- R2: Error bits 0 (lost-lock), 1 (lost-sync) and 2 (FIFO overflow) are severe. `cdf_err_o` is high in the cycle after any of them is set and stays high while any of them is set. A `fifo_ovf_i` pulse sets bit 2.
- R3: `soft_err_i` sets error bit 3 (non-severe). This raises `svt_err_o` but not `cdf_err_o`. Bit 3 is cleared by the next end-of-event strobe unless `soft_err_i` is high in that cycle. `svt_err_o` is high whenever any error bit is set.
- R4: A register write to address 0 clears every error bit whose `reg_wdata_i` bit is 1. INIT clears all error bits and the expected tag. A condition setting a bit in the same cycle wins over the clear.
- R5: Whenever the error register is all clear and at least one bit is being set, the shadow register captures the set vector. It is changed neither by INIT nor by writes, only by reset. It is read at address 1.
- R6: When the synchronized link lock-lost input is high, error bit 0 is set two clock edges after the input changes plus one for the register. `llk_oe_o` is high while bit 0 is set, and `llk_do_o` is always 0, so the line is pulled low.
- R7: `chain_o` is a register that holds (synchronized backplane line low) OR (synchronized `chain_i` high). It follows its inputs three edges later.
- R8: The LED outputs are registered copies of `run_i`, `cdf_err_o` and `svt_err_o`, each ANDed with a blink phase. The phase is on after reset and toggles every BLINK_DIV clocks. With BLINK_EN = 0 the LEDs are steady.
- R9: A read strobe loads the addressed register (0 = error register, 1 = shadow) into `reg_rdata_o` on the next edge. The value shown is the one before that edge's update. Otherwise `reg_rdata_o` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| init_i | input | 1 | INIT pulse |
| lock_lost_i | input | 1 | Link lock-lost status, asynchronous |
| fifo_ovf_i | input | 1 | FIFO overflow pulse |
| soft_err_i | input | 1 | Non-severe error condition |
| evt_end_i | input | 1 | End-of-event strobe |
| evt_tag_i | input | 8 | Event tag received with the end-of-event word |
| run_i | input | 1 | Board run state |
| llk_bus_i | input | 1 | Sampled lost-lock backplane line, active low, asynchronous |
| chain_i | input | 1 | Daisy-chain input from upstream board, asynchronous |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 1 | Register address: 0 error, 1 shadow |
| reg_wdata_i | input | 4 | Write data, 1 clears the bit |
| reg_rdata_o | output | 4 | Read data |
| svt_err_o | output | 1 | SVT error line |
| cdf_err_o | output | 1 | CDF error line |
| llk_oe_o | output | 1 | Lost-lock open-collector enable |
| llk_do_o | output | 1 | Lost-lock open-collector data |
| chain_o | output | 1 | Daisy-chain output |
| led_run_o | output | 1 | Green LED |
| led_cdf_o | output | 1 | Red LED |
| led_svt_o | output | 1 | Yellow LED |

## Verification
A software clear can land in the same cycle as a new error being set. The bench provokes this with a write of all ones at address 0 alongside a FIFO overflow pulse, and with INIT alongside a non-severe error. The bench's behavioural model requires the new bit to survive, so `svt_err_o` and `cdf_err_o` must stay up. The shadow register must then show the new cause only if the register was empty before.

// File: rtl/board_err_pkg.sv
package board_err_pkg;
  localparam int ERR_W    = 4;
  localparam int ERR_LOCK = 0;
  localparam int ERR_SYNC = 1;
  localparam int ERR_FIFO = 2;
  localparam int ERR_SOFT = 3;
  localparam int SEV_W    = 3;
  typedef logic [ERR_W-1:0] err_vec_t;
  typedef enum logic {ADDR_ERR = 1'b0, ADDR_SHADOW = 1'b1} reg_addr_e;
endpackage

// File: rtl/bec_sync.sv
module bec_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] st_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic [W-1:0] st_d;
    if (g == 0) begin : g_first
      assign st_d = d_i;
    end else begin : g_next
      assign st_d = st_q[g-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q[g] <= RST_VAL;
      else        st_q[g] <= st_d;
    end
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/bec_err_core.sv
module bec_err_core
  import board_err_pkg::*;
#(
  parameter int TAG_W = 8,
  parameter bit SHADOW_EN = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init_i,
  input  logic             lock_s_i,
  input  logic             fifo_ovf_i,
  input  logic             soft_err_i,
  input  logic             evt_end_i,
  input  logic [TAG_W-1:0] evt_tag_i,
  input  logic             reg_wr_i,
  input  logic             reg_rd_i,
  input  logic             reg_addr_i,
  input  err_vec_t         reg_wdata_i,
  output err_vec_t         err_o,
  output err_vec_t         shadow_o,
  output err_vec_t         rdata_o
);
  err_vec_t err_q, err_d, set_vec, clr_vec, shadow_q, shadow_d, rdata_q, rdata_d;
  logic [TAG_W-1:0] exp_q, exp_d;
  logic rd_en, exp_en;

  always_comb begin
    set_vec = '0;
    set_vec[ERR_LOCK] = lock_s_i;
    set_vec[ERR_SYNC] = evt_end_i && (evt_tag_i != exp_q);
    set_vec[ERR_FIFO] = fifo_ovf_i;
    set_vec[ERR_SOFT] = soft_err_i;
    clr_vec = '0;
    if (reg_wr_i && reg_addr_i == ADDR_ERR) clr_vec = reg_wdata_i;
    if (evt_end_i) clr_vec[ERR_SOFT] = 1'b1;
    if (init_i) clr_vec = '1;
    err_d = set_vec | (err_q & ~clr_vec);
  end

  assign exp_en = init_i || evt_end_i;
  assign exp_d  = init_i ? '0 : exp_q + 1'b1;

  if (SHADOW_EN) begin : g_shadow
    assign shadow_d = (err_q == '0 && set_vec != '0) ? set_vec : shadow_q;
  end else begin : g_no_shadow
    assign shadow_d = '0;
  end

  assign rd_en   = reg_rd_i;
  assign rdata_d = (reg_addr_i == ADDR_SHADOW) ? shadow_q : err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q    <= '0;
      exp_q    <= '0;
      shadow_q <= '0;
      rdata_q  <= '0;
    end else begin
      err_q    <= err_d;
      shadow_q <= shadow_d;
      if (exp_en) exp_q   <= exp_d;
      if (rd_en)  rdata_q <= rdata_d;
    end
  end

  assign err_o    = err_q;
  assign shadow_o = shadow_q;
  assign rdata_o  = rdata_q;
endmodule

// File: rtl/bec_led_blink.sv
module bec_led_blink #(
  parameter int N = 3,
  parameter int BLINK_DIV = 62_500_000,
  parameter bit BLINK_EN = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] cond_i,
  output logic [N-1:0] led_o
);
  localparam int CNT_W = (BLINK_DIV > 1) ? $clog2(BLINK_DIV) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BLINK_DIV - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic ph_q, ph_d, wrap;
  logic [N-1:0] led_q, led_d;

  assign wrap  = (cnt_q == CNT_LAST);
  assign cnt_d = wrap ? '0 : cnt_q + 1'b1;
  assign ph_d  = wrap ? ~ph_q : ph_q;
  assign led_d = cond_i & {N{ph_q | ~BLINK_EN}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ph_q  <= 1'b1;
      led_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      ph_q  <= ph_d;
      led_q <= led_d;
    end
  end

  assign led_o = led_q;
endmodule

// File: rtl/board_err_ctrl.sv
module board_err_ctrl
  import board_err_pkg::*;
#(
  parameter int TAG_W = 8,
  parameter int SYNC_STAGES = 2,
  parameter bit SHADOW_EN = 1'b1,
  parameter int BLINK_DIV = 62_500_000,
  parameter bit BLINK_EN = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init_i,
  input  logic             lock_lost_i,
  input  logic             fifo_ovf_i,
  input  logic             soft_err_i,
  input  logic             evt_end_i,
  input  logic [TAG_W-1:0] evt_tag_i,
  input  logic             run_i,
  input  logic             llk_bus_i,
  input  logic             chain_i,
  input  logic             reg_wr_i,
  input  logic             reg_rd_i,
  input  logic             reg_addr_i,
  input  logic [3:0]       reg_wdata_i,
  output logic [3:0]       reg_rdata_o,
  output logic             svt_err_o,
  output logic             cdf_err_o,
  output logic             llk_oe_o,
  output logic             llk_do_o,
  output logic             chain_o,
  output logic             led_run_o,
  output logic             led_cdf_o,
  output logic             led_svt_o
);
  logic [2:0] async_s;
  logic lock_s, bus_s, chain_s, chain_q, chain_d;
  err_vec_t err_q, shadow_q;
  logic [2:0] led_cond, led_q;

  bec_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d_i({chain_i, llk_bus_i, lock_lost_i}),
    .q_o(async_s)
  );
  assign lock_s  = async_s[0];
  assign bus_s   = async_s[1];
  assign chain_s = async_s[2];

  bec_err_core #(.TAG_W(TAG_W), .SHADOW_EN(SHADOW_EN)) u_core (
    .clk(clk), .rst_n(rst_n), .init_i(init_i), .lock_s_i(lock_s),
    .fifo_ovf_i(fifo_ovf_i), .soft_err_i(soft_err_i), .evt_end_i(evt_end_i),
    .evt_tag_i(evt_tag_i), .reg_wr_i(reg_wr_i), .reg_rd_i(reg_rd_i),
    .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
    .err_o(err_q), .shadow_o(shadow_q), .rdata_o(reg_rdata_o)
  );

  assign svt_err_o = |err_q;
  assign cdf_err_o = |err_q[SEV_W-1:0];
  assign llk_oe_o  = err_q[ERR_LOCK];
  assign llk_do_o  = 1'b0;

  assign chain_d = ~bus_s | chain_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= 1'b0;
    else        chain_q <= chain_d;
  end
  assign chain_o = chain_q;

  assign led_cond = {svt_err_o, cdf_err_o, run_i};
  bec_led_blink #(.N(3), .BLINK_DIV(BLINK_DIV), .BLINK_EN(BLINK_EN)) u_led (
    .clk(clk), .rst_n(rst_n), .cond_i(led_cond), .led_o(led_q)
  );
  assign led_run_o = led_q[0];
  assign led_cdf_o = led_q[1];
  assign led_svt_o = led_q[2];
endmodule

// File: rtl/board_err_ctrl_chk.sv
module board_err_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       init_i,
  input logic       fifo_ovf_i,
  input logic       soft_err_i,
  input logic       evt_end_i,
  input logic       reg_wr_i,
  input logic       reg_addr_i,
  input logic [3:0] reg_wdata_i,
  input logic       lock_s,
  input logic       svt_err_o,
  input logic       cdf_err_o,
  input logic       llk_oe_o,
  input logic       led_cdf_o,
  input logic [3:0] shadow_q
);
  // R2
  fifo_sets_cdf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_ovf_i |=> cdf_err_o);
  // R3
  cdf_implies_svt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cdf_err_o |-> svt_err_o);
  // R6
  oc_drive_cdf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    llk_oe_o |-> cdf_err_o);
  // R4
  full_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_i && !reg_addr_i && (&reg_wdata_i) && !fifo_ovf_i && !soft_err_i
     && !evt_end_i && !lock_s) |=> !svt_err_o);
  // R5
  shadow_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (init_i && svt_err_o) |=> $stable(shadow_q));
  // R8
  led_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    led_cdf_o |-> $past(cdf_err_o));
endmodule

bind board_err_ctrl board_err_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .init_i(init_i), .fifo_ovf_i(fifo_ovf_i),
  .soft_err_i(soft_err_i), .evt_end_i(evt_end_i), .reg_wr_i(reg_wr_i),
  .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i), .lock_s(lock_s),
  .svt_err_o(svt_err_o), .cdf_err_o(cdf_err_o), .llk_oe_o(llk_oe_o),
  .led_cdf_o(led_cdf_o), .shadow_q(shadow_q)
);

// File: tb/board_err_ctrl_tb_top.sv
`timescale 1ns/1ps
module board_err_ctrl_tb_top;
  localparam int DIV = 8;
  localparam int WD_LIMIT = 20000;

  logic clk = 1'b0;
  logic rst_n;
  logic init_i, lock_lost_i, fifo_ovf_i, soft_err_i, evt_end_i, run_i;
  logic llk_bus_i, chain_i, reg_wr_i, reg_rd_i, reg_addr_i;
  logic [7:0] evt_tag_i;
  logic [3:0] reg_wdata_i, reg_rdata_o;
  logic svt_err_o, cdf_err_o, llk_oe_o, llk_do_o, chain_o;
  logic led_run_o, led_cdf_o, led_svt_o;

  int n_checks = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 0;

  always #2 clk = ~clk;

  board_err_ctrl #(.BLINK_DIV(DIV)) dut_i (
    .clk(clk), .rst_n(rst_n), .init_i(init_i), .lock_lost_i(lock_lost_i),
    .fifo_ovf_i(fifo_ovf_i), .soft_err_i(soft_err_i), .evt_end_i(evt_end_i),
    .evt_tag_i(evt_tag_i), .run_i(run_i), .llk_bus_i(llk_bus_i), .chain_i(chain_i),
    .reg_wr_i(reg_wr_i), .reg_rd_i(reg_rd_i), .reg_addr_i(reg_addr_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .svt_err_o(svt_err_o),
    .cdf_err_o(cdf_err_o), .llk_oe_o(llk_oe_o), .llk_do_o(llk_do_o),
    .chain_o(chain_o), .led_run_o(led_run_o), .led_cdf_o(led_cdf_o),
    .led_svt_o(led_svt_o)
  );

  // Behavioural reference model
  bit [3:0] m_err, m_sh, m_rd;
  bit [7:0] m_exp;
  bit m_chain, m_ph;
  bit [2:0] m_led;
  int m_edges;
  bit lock_hist[$], bus_hist[$], chn_hist[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_err = 0; m_sh = 0; m_rd = 0; m_exp = 0; m_chain = 0;
      m_ph = 1; m_led = 0; m_edges = 0;
      lock_hist = '{0, 0}; bus_hist = '{1, 1}; chn_hist = '{0, 0};
    end else begin
      bit [3:0] nerr, setv;
      bit lk, bs, ch, cdf, svt;
      lk = lock_hist[0]; bs = bus_hist[0]; ch = chn_hist[0];
      setv = {soft_err_i, fifo_ovf_i, evt_end_i && (evt_tag_i != m_exp), lk};
      nerr = m_err;
      if (reg_wr_i && !reg_addr_i) nerr = nerr & ~reg_wdata_i;
      if (evt_end_i) nerr[3] = 0;
      if (init_i) nerr = 0;
      nerr = nerr | setv;
      if (reg_rd_i) m_rd = reg_addr_i ? m_sh : m_err;
      if (m_err == 0 && setv != 0) m_sh = setv;
      cdf = |m_err[2:0]; svt = |m_err;
      m_led = {svt & m_ph, cdf & m_ph, run_i & m_ph};
      m_chain = !bs || ch;
      if (init_i) m_exp = 0; else if (evt_end_i) m_exp = m_exp + 1;
      m_err = nerr;
      m_edges++;
      if (m_edges % DIV == 0) m_ph = !m_ph;
      void'(lock_hist.pop_front()); lock_hist.push_back(lock_lost_i);
      void'(bus_hist.pop_front());  bus_hist.push_back(llk_bus_i);
      void'(chn_hist.pop_front());  chn_hist.push_back(chain_i);
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h at cycle %0d", req, what, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n && !done) begin
      chk("R3", "svt_err_o", svt_err_o, |m_err);
      chk("R2", "cdf_err_o", cdf_err_o, |m_err[2:0]);
      chk("R6", "llk_oe_o", llk_oe_o, m_err[0]);
      chk("R6", "llk_do_o", llk_do_o, 0);
      chk("R7", "chain_o", chain_o, m_chain);
      chk("R9", "reg_rdata_o", reg_rdata_o, m_rd);
      chk("R8", "leds", {led_svt_o, led_cdf_o, led_run_o}, m_led);
    end
    if (cyc > WD_LIMIT && !done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog expired: actual %0d expected < %0d", cyc, WD_LIMIT);
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic evt(bit [7:0] tag);
    evt_end_i = 1; evt_tag_i = tag; tick(1);
    evt_end_i = 0; tick(1);
  endtask

  task automatic rd(bit a);
    reg_rd_i = 1; reg_addr_i = a; tick(1);
    reg_rd_i = 0; tick(1);
  endtask

  task automatic wr(bit [3:0] d);
    reg_wr_i = 1; reg_addr_i = 0; reg_wdata_i = d; tick(1);
    reg_wr_i = 0; tick(1);
  endtask

  initial begin
    rst_n = 0; init_i = 0; lock_lost_i = 0; fifo_ovf_i = 0; soft_err_i = 0;
    evt_end_i = 0; evt_tag_i = 0; run_i = 0; llk_bus_i = 1; chain_i = 0;
    reg_wr_i = 0; reg_rd_i = 0; reg_addr_i = 0; reg_wdata_i = 0;
    tick(3);
    // Reset state (R2, R3, R7)
    chk("R3", "reset svt", svt_err_o, 0);
    chk("R2", "reset cdf", cdf_err_o, 0);
    chk("R7", "reset chain", chain_o, 0);
    rst_n = 1; tick(2);
    // R1: matching tags, then a mismatch
    evt(0); evt(1); evt(2);
    chk("R1", "no lost-sync on matching tags", svt_err_o, 0);
    evt(7); tick(1);
    chk("R1", "lost-sync after tag mismatch", cdf_err_o, 1);
    rd(0); chk("R9", "error reg read", reg_rdata_o, 4'b0010);
    rd(1); chk("R5", "shadow holds lost-sync", reg_rdata_o, 4'b0010);
    wr(4'hF); chk("R4", "clear by write", svt_err_o, 0);
    // R2: FIFO overflow
    fifo_ovf_i = 1; tick(1); fifo_ovf_i = 0; tick(1);
    chk("R2", "fifo overflow severe", cdf_err_o, 1);
    wr(4'b0100);
    // R3: non-severe, self-clears on next event (expected tag is now 4)
    soft_err_i = 1; tick(1); soft_err_i = 0; tick(1);
    chk("R3", "soft sets svt", svt_err_o, 1);
    chk("R3", "soft not cdf", cdf_err_o, 0);
    evt(4);
    chk("R3", "soft self-cleared", svt_err_o, 0);
    // R6: lost-lock
    lock_lost_i = 1; tick(5); lock_lost_i = 0; tick(3);
    chk("R6", "open-collector enable", llk_oe_o, 1);
    wr(4'b0001); chk("R6", "lock cleared", llk_oe_o, 0);
    // Coincidence: clear-all write together with FIFO overflow (R4)
    fifo_ovf_i = 1; tick(1); fifo_ovf_i = 0;
    reg_wr_i = 1; reg_wdata_i = 4'hF; fifo_ovf_i = 1; tick(1);
    reg_wr_i = 0; fifo_ovf_i = 0; tick(1);
    chk("R4", "set beats clear", cdf_err_o, 1);
    // INIT with soft error at once; shadow must survive INIT (R5)
    init_i = 1; soft_err_i = 1; tick(1); init_i = 0; soft_err_i = 0; tick(1);
    chk("R4", "set beats INIT", cdf_err_o, 0);
    rd(1); chk("R5", "shadow survives INIT", reg_rdata_o, 4'b0100);
    // R7: backplane line and chain input
    llk_bus_i = 0; tick(4); llk_bus_i = 1; tick(4);
    chain_i = 1; tick(4); chain_i = 0; tick(4);
    // R8: blinking LEDs
    run_i = 1; tick(40); run_i = 0; tick(2);
    // R1: tag wrap after INIT
    init_i = 1; tick(1); init_i = 0; wr(4'hF);
    for (int i = 0; i < 257; i++) evt(8'(i));
    chk("R1", "tag wraps at 8 bits", cdf_err_o, 0);
    tick(4);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule